// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block steps the 13-bit fetch address of a small processor core. It holds the program counter, an eight-slot circular stack of return addresses, and a page register. Software writes the page register ahead of a subroutine jump. Without a request, the counter moves to the next word each cycle. A call loads an 11-bit immediate into the low counter bits. The two upper counter bits come from bits 4 and 3 of the page register. A return reloads the whole counter from the stack.

The fetch unit drives a stall input that freezes sequencing. It also watches a busy output. A call or return redirects the counter on the cycle it is accepted. The following cycle is a dead slot: busy is high, the word fetched in that slot must be replaced by a no-op, and the counter does not move. Each transfer therefore costs two cycles. No status flag is produced.

Top module: `pcs_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the busy flag, the page register, the stack pointer and all stack slots are cleared to zero, so `fetch_addr_o` reads 0000h and `busy_o` reads 0.
- R2: In a cycle with no stall, no busy slot and no request, the counter advances by exactly one.
- R3: Sequential advance wraps from 1FFFh to 0000h. A call made at 1FFFh saves 0000h as its return address.
- R4: While `stall_i` is high, the counter and the busy flag keep their values and any call or return request is not taken. A request still present once the stall drops is taken then.
- R5: An accepted call sets counter bits 10..0 to `call_imm_i` and bits 12..11 to bits 4..3 of the page register.
- R6: An accepted call pushes counter+1. An accepted return pops the most recent entry into all 13 counter bits, so nested calls unwind in reverse order.
- R7: After an accepted call or return, `busy_o` is high for exactly one non-stalled cycle. In that cycle the counter holds and any call or return request is ignored.
- R8: A return leaves the page register unchanged, so a later call still uses the page value written before the return.
- R9: The stack holds eight entries and wraps circularly. A ninth push overwrites the oldest entry without any error, and popping past the oldest entry continues around the ring.
- R10: If a call and a return are requested in the same cycle, only the call is carried out.
- R11: A page write updates the register at the clock edge, in any cycle, including stalled and busy ones. A call accepted in the same cycle as a page write uses the previous page value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Fetch stall; freezes sequencing |
| call_req_i | input | 1 | Subroutine call request |
| call_imm_i | input | 11 | Call target, low counter bits |
| ret_req_i | input | 1 | Subroutine return request |
| page_we_i | input | 1 | Page register write enable |
| page_wdata_i | input | 8 | Page register write data (bits 4..3 used for calls) |
| fetch_addr_o | output | 13 | Current fetch address |
| busy_o | output | 1 | Dead slot after a transfer; fetched word becomes a no-op |

## Verification
Three pairs of functions can land on the same edge. A page write can coincide with a call. A call can coincide with a return. A request can arrive during a stall or a busy slot. The bench raises each pair of inputs together in one cycle. A behavioural model, built from integers and an array, decides which function wins and which page value the call target takes. The model's counter and busy flag are compared with the ports after every clock.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    parameter int PC_W         = 13;
    parameter int IMM_W        = 11;
    parameter int PAGE_W       = 8;
    parameter int PAGE_SEL_LSB = 3;
    parameter int STK_DEPTH    = 8;

    localparam int SEL_W = PC_W - IMM_W;
    localparam int SP_W  = $clog2(STK_DEPTH);

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [IMM_W-1:0]  imm_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SP_W-1:0]   sp_t;

    typedef enum logic [1:0] {
        OP_SEQ,
        OP_CALL,
        OP_RET,
        OP_HOLD
    } pc_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        pc_t  push_val;
    } stk_cmd_t;

    function automatic pc_t pc_inc(pc_t p);
        return p + pc_t'(1);
    endfunction

    function automatic pc_t call_dest(page_t pg, imm_t imm);
        return {pg[PAGE_SEL_LSB +: SEL_W], imm};
    endfunction

endpackage

// File: rtl/pcs_page.sv
module pcs_page
    import pcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  page_t wdata,
    output page_t page_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (we) begin
            page_q <= wdata;
        end
    end

    // R8 / R11: the register only moves on an explicit write
    p_page_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(page_q));

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack
    import pcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  stk_cmd_t cmd,
    output pc_t      top_o
);

    pc_t slot_q [STK_DEPTH];
    sp_t sp_q;
    sp_t sp_dec;

    assign sp_dec = sp_q - sp_t'(1);
    assign top_o  = slot_q[sp_dec];

    for (genvar g = 0; g < STK_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (cmd.push && sp_q == sp_t'(g)) begin
                slot_q[g] <= cmd.push_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (cmd.push) begin
            sp_q <= sp_q + sp_t'(1);
        end else if (cmd.pop) begin
            sp_q <= sp_dec;
        end
    end

    // R9: pointer advances around the ring on every push, no saturation
    p_push_adv_r9: assert property (@(posedge clk) disable iff (rst)
        cmd.push |=> sp_q == sp_t'($past(sp_q) + sp_t'(1)));

    // R6: pop walks back one slot
    p_pop_back_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.pop |=> sp_q == sp_t'($past(sp_q) - sp_t'(1)));

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(cmd.push && cmd.pop));

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
    import pcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stall,
    input  logic     call_req,
    input  logic     ret_req,
    input  pc_t      call_pc,
    input  pc_t      stk_top,
    output pc_t      pc_o,
    output logic     busy_o,
    output stk_cmd_t stk_cmd
);

    pc_t    pc_q;
    logic   busy_q;
    pc_op_e op;

    always_comb begin
        if (stall || busy_q) begin
            op = OP_HOLD;
        end else if (call_req) begin
            op = OP_CALL;
        end else if (ret_req) begin
            op = OP_RET;
        end else begin
            op = OP_SEQ;
        end
    end

    always_comb begin
        stk_cmd.push     = (op == OP_CALL);
        stk_cmd.pop      = (op == OP_RET);
        stk_cmd.push_val = pc_inc(pc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            busy_q <= 1'b0;
        end else if (!stall) begin
            busy_q <= (op == OP_CALL) || (op == OP_RET);
            unique case (op)
                OP_SEQ:  pc_q <= pc_inc(pc_q);
                OP_CALL: pc_q <= call_pc;
                OP_RET:  pc_q <= stk_top;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o   = pc_q;
    assign busy_o = busy_q;

    // R7: dead slot lasts a single unstalled cycle
    p_busy_single_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q && !stall |=> !busy_q);

    // R7: counter frozen across the dead slot
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(pc_q));

    // R4: stall freezes sequencing state
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_q) && $stable(busy_q));

    // R2: plain advance by one
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !busy_q && !call_req && !ret_req)
            |=> pc_q == pc_t'($past(pc_q) + pc_t'(1)));

endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              call_req_i,
    input  logic [IMM_W-1:0]  call_imm_i,
    input  logic              ret_req_i,
    input  logic              page_we_i,
    input  logic [PAGE_W-1:0] page_wdata_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              busy_o
);

    page_t    page_q;
    pc_t      stk_top;
    pc_t      call_pc;
    stk_cmd_t stk_cmd;

    pcs_page u_page (
        .clk    (clk),
        .rst    (rst),
        .we     (page_we_i),
        .wdata  (page_wdata_i),
        .page_q (page_q)
    );

    assign call_pc = call_dest(page_q, call_imm_i);

    pcs_stack u_stack (
        .clk   (clk),
        .rst   (rst),
        .cmd   (stk_cmd),
        .top_o (stk_top)
    );

    pcs_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall_i),
        .call_req (call_req_i),
        .ret_req  (ret_req_i),
        .call_pc  (call_pc),
        .stk_top  (stk_top),
        .pc_o     (fetch_addr_o),
        .busy_o   (busy_o),
        .stk_cmd  (stk_cmd)
    );

    // R5: accepted call lands on the immediate and opens a dead slot
    p_call_dest_r5: assert property (@(posedge clk) disable iff (rst)
        (call_req_i && !stall_i && !busy_o)
            |=> fetch_addr_o[IMM_W-1:0] == $past(call_imm_i) && busy_o);

    // R10: a call never pops, even with a simultaneous return
    p_call_wins_r10: assert property (@(posedge clk) disable iff (rst)
        call_req_i |-> !stk_cmd.pop);

endmodule

// File: tb/tb_pcs_sequencer.sv
module tb_pcs_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic        call_req_i = 1'b0;
    logic [10:0] call_imm_i = '0;
    logic        ret_req_i = 1'b0;
    logic        page_we_i = 1'b0;
    logic [7:0]  page_wdata_i = '0;
    logic [12:0] fetch_addr_o;
    logic        busy_o;

    pcs_sequencer dut (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall_i),
        .call_req_i   (call_req_i),
        .call_imm_i   (call_imm_i),
        .ret_req_i    (ret_req_i),
        .page_we_i    (page_we_i),
        .page_wdata_i (page_wdata_i),
        .fetch_addr_o (fetch_addr_o),
        .busy_o       (busy_o)
    );

    always #5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    int m_pc, m_busy, m_page, m_sp;
    int m_stk [8];

    // behavioural reference, advanced once per clock edge
    task automatic step(input string tag);
        int npage;
        @(posedge clk);
        if (rst) begin
            m_pc = 0; m_busy = 0; m_page = 0; m_sp = 0;
            for (int i = 0; i < 8; i++) m_stk[i] = 0;
        end else begin
            npage = page_we_i ? int'(page_wdata_i) : m_page;
            if (!stall_i) begin
                if (m_busy != 0) begin
                    m_busy = 0;
                end else if (call_req_i) begin
                    m_stk[m_sp] = (m_pc + 1) % 8192;
                    m_sp = (m_sp + 1) % 8;
                    m_pc = (((m_page >> 3) & 3) << 11) | int'(call_imm_i);
                    m_busy = 1;
                end else if (ret_req_i) begin
                    m_sp = (m_sp + 7) % 8;
                    m_pc = m_stk[m_sp];
                    m_busy = 1;
                end else begin
                    m_pc = (m_pc + 1) % 8192;
                end
            end
            m_page = npage;
        end
        #1;
        n_run++;
        if (fetch_addr_o !== 13'(m_pc) || busy_o !== m_busy[0]) begin
            n_fail++;
            $display("FAIL %s: fetch_addr=%h busy=%b, expected fetch_addr=%h busy=%b",
                     tag, fetch_addr_o, busy_o, 13'(m_pc), m_busy[0]);
        end
    endtask

    task automatic do_call(input logic [10:0] imm, input string tag);
        call_req_i = 1'b1; call_imm_i = imm;
        step(tag);
        call_req_i = 1'b0;
        step(tag);
    endtask

    task automatic do_ret(input string tag);
        ret_req_i = 1'b1;
        step(tag);
        ret_req_i = 1'b0;
        step(tag);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, all requirements unconfirmed");
        finish_run();
    end

    initial begin
        // R1: reset state, request inputs held active are overridden
        call_req_i = 1'b1; page_we_i = 1'b1; page_wdata_i = 8'hFF;
        step("R1"); step("R1");
        call_req_i = 1'b0; page_we_i = 1'b0;
        rst = 1'b0;
        // R2: plain advance
        step("R2"); step("R2"); step("R2");

        // R11: page write with call in the same cycle -> old page (0)
        page_we_i = 1'b1; page_wdata_i = 8'h18;
        call_req_i = 1'b1; call_imm_i = 11'h123;
        step("R11");
        page_we_i = 1'b0; call_req_i = 1'b0;
        // R7: return request during dead slot is ignored
        ret_req_i = 1'b1;
        step("R7");
        ret_req_i = 1'b0;
        step("R7"); step("R2");

        // R5: call now sees page bits 4..3 = 3
        do_call(11'h045, "R5");
        step("R2");
        // R6: unwind both calls
        do_ret("R6");
        step("R6");
        do_ret("R6");
        step("R6");
        // R8: page survives returns
        do_call(11'h200, "R8");
        step("R8");

        // R10: call and return together -> call
        call_req_i = 1'b1; ret_req_i = 1'b1; call_imm_i = 11'h0AA;
        step("R10");
        call_req_i = 1'b0; ret_req_i = 1'b0;
        step("R10");
        do_ret("R10");

        // R4: stall with a pending call, then release
        stall_i = 1'b1; call_req_i = 1'b1; call_imm_i = 11'h3C3;
        step("R4"); step("R4");
        stall_i = 1'b0;
        step("R4");
        call_req_i = 1'b0;
        // R4: stall lands on the dead slot
        stall_i = 1'b1;
        step("R4"); step("R4");
        stall_i = 1'b0;
        step("R4"); step("R4");

        // R11: page write during stall and during a dead slot
        stall_i = 1'b1; page_we_i = 1'b1; page_wdata_i = 8'h08;
        step("R11");
        stall_i = 1'b0; page_we_i = 1'b0;
        call_req_i = 1'b1; call_imm_i = 11'h011;
        step("R11");
        call_req_i = 1'b0; page_we_i = 1'b1; page_wdata_i = 8'h10;
        step("R11");
        page_we_i = 1'b0;
        do_call(11'h022, "R11");
        do_ret("R11");
        do_ret("R11");

        // R9: nine nested calls then ten returns around the ring
        for (int k = 0; k < 9; k++) begin
            do_call(11'(16 * k + 5), "R9");
            step("R9");
        end
        for (int k = 0; k < 10; k++) begin
            do_ret("R9");
            step("R9");
        end

        // R3: wrap of advance and of the saved return address
        page_we_i = 1'b1; page_wdata_i = 8'h18;
        step("R3");
        page_we_i = 1'b0;
        do_call(11'h7FF, "R3");
        step("R3");
        do_call(11'h7FE, "R3");
        step("R3");
        call_req_i = 1'b1; call_imm_i = 11'h010;
        step("R3");
        call_req_i = 1'b0;
        step("R3");
        do_ret("R3");
        step("R3");

        finish_run();
    end

endmodule